// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block gives a processor 24 general-purpose lines arranged as two full ports, A and B, and a third port C whose upper and lower halves are steered on their own. The processor reaches it through a small 8-bit register interface: an active-low select, active-low read and write strobes, and a 2-bit address. Three addresses reach the ports. The fourth reaches a control register, which either sets the direction of all four groups at once or forces a single port C line high or low.

Each line has separate input, output and output-enable signals, so the pad ring or an external tristate stage builds the physical pin. Output values are held in latches. Input values are not stored: a read returns the pins as they are during that read. Writes take effect on the rising clock edge while select and write are both low. Read data is combinational and is valid while select and read are both low.

Top module: `par_io_port`

## Requirements
- R1: While `rst` is high, every output latch is cleared to 0, every output-enable is low (all groups are inputs), and a read of address 3 returns 0x9B.
- R2: A write to address 3 with bit 7 = 1 sets directions. Bit 4 = 1 makes port A an input, bit 3 = 1 makes C[7:4] an input, bit 1 = 1 makes port B an input, and bit 0 = 1 makes C[3:0] an input. A 0 bit makes that group an output. A read of address 3 returns {1, 0, 0, A-in, Cup-in, 0, B-in, Clo-in}.
- R3: Every direction write clears all three output latches to 0.
- R4: Each output-enable bit is high exactly while its group is set as an output.
- R5: A write to address 0, 1 or 2 loads the port A, B or C latch. The pin outputs always show the latch contents.
- R6: A read of address 0 or 1 on a port set as input returns that port's input pins in the same cycle, with no register in the path.
- R7: A read of a port set as output returns its latch. A read of port C returns the latch for output halves and the pins for input halves.
- R8: A write to address 3 with bit 7 = 0 sets port C latch bit number din[3:1] to din[0]. No other latch bit and no direction changes.
- R9: While `cs_n` is high, writes have no effect and `dout` is 0.
- R10: When no read is in progress, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 = A, 1 = B, 2 = C, 3 = control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not reading |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench uses the default width of 8. At this width every control bit position is fixed and every one of the eight port C bit addresses can be reached. Fixed, distinct pin patterns on the three ports show whether a read came from the pins or from a latch. Direction words that make only one port C half an input show that the halves are selected separately. Set/clear commands at bit 0 and bit 7 cover both ends of the bit index.

// File: rtl/par_io_port.sv
module par_io_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int H  = W / 2;
  localparam int IW = $clog2(W);

  logic a_in, b_in, cu_in, cl_in;
  logic [W-1:0] la, lb, lc;
  logic [W-1:0] c_view, ctl_view;

  wire wr_en = !cs_n && !wr_n;
  wire rd_en = !cs_n && !rd_n;
  wire ctl_wr = wr_en && (addr == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_in  <= 1'b1;
      b_in  <= 1'b1;
      cu_in <= 1'b1;
      cl_in <= 1'b1;
      la    <= '0;
      lb    <= '0;
      lc    <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: la <= din;
        2'd1: lb <= din;
        2'd2: lc <= din;
        default: begin
          if (din[7]) begin
            a_in  <= din[4];
            cu_in <= din[3];
            b_in  <= din[1];
            cl_in <= din[0];
            la    <= '0;
            lb    <= '0;
            lc    <= '0;
          end else begin
            lc[din[IW:1]] <= din[0];
          end
        end
      endcase
    end
  end

  assign pa_out = la;
  assign pb_out = lb;
  assign pc_out = lc;
  assign pa_oe  = {W{~a_in}};
  assign pb_oe  = {W{~b_in}};
  assign pc_oe  = {{H{~cu_in}}, {H{~cl_in}}};

  assign c_view = {cu_in ? pc_in[W-1:H] : lc[W-1:H],
                   cl_in ? pc_in[H-1:0] : lc[H-1:0]};

  always_comb begin
    ctl_view    = '0;
    ctl_view[7] = 1'b1;
    ctl_view[4] = a_in;
    ctl_view[3] = cu_in;
    ctl_view[1] = b_in;
    ctl_view[0] = cl_in;
  end

  always_comb begin
    dout = '0;
    if (rd_en) begin
      case (addr)
        2'd0:    dout = a_in ? pa_in : la;
        2'd1:    dout = b_in ? pb_in : lb;
        2'd2:    dout = c_view;
        default: dout = ctl_view;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
             pa_out == '0 && pb_out == '0 && pc_out == '0));

  // R2 R4
  mode_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && din[7]) |=> (pa_oe == {W{~$past(din[4])}} &&
                            pb_oe == {W{~$past(din[1])}} &&
                            pc_oe == {{H{~$past(din[3])}}, {H{~$past(din[0])}}}));

  // R3
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && din[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  // R8
  bit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !din[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                             $stable(pa_out) && $stable(pb_out) &&
                             pc_out[$past(din[IW:1])] == $past(din[0])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

// File: tb/sim_par_io_port.sv
module sim_par_io_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hC3, pc_in = 8'h96;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  par_io_port #(.W(8)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // {is_write, addr, data_or_expected}; reqs noted per entry
  localparam int NV = 28;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd3, 8'h9B},  // R1 control after reset
    {1'b0, 2'd0, 8'h5A},  // R6
    {1'b0, 2'd1, 8'hC3},  // R6
    {1'b0, 2'd2, 8'h96},  // R7 all-input C
    {1'b1, 2'd3, 8'h80},  // R2 all outputs
    {1'b0, 2'd0, 8'h00},  // R3
    {1'b1, 2'd0, 8'h11},  // R5
    {1'b0, 2'd0, 8'h11},  // R7
    {1'b1, 2'd1, 8'h22},
    {1'b0, 2'd1, 8'h22},  // R7
    {1'b1, 2'd2, 8'hF0},
    {1'b0, 2'd2, 8'hF0},  // R7
    {1'b1, 2'd3, 8'h01},  // R8 set bit 0
    {1'b0, 2'd2, 8'hF1},  // R8
    {1'b1, 2'd3, 8'h0E},  // R8 clear bit 7
    {1'b0, 2'd2, 8'h71},  // R8
    {1'b0, 2'd0, 8'h11},  // R8 port A untouched
    {1'b1, 2'd3, 8'h88},  // R2 C upper input
    {1'b0, 2'd2, 8'h90},  // R3 R7 pins upper, latch lower
    {1'b0, 2'd3, 8'h88},  // R2
    {1'b1, 2'd2, 8'h3C},
    {1'b0, 2'd2, 8'h9C},  // R7
    {1'b1, 2'd3, 8'h81},  // R2 C lower input
    {1'b1, 2'd2, 8'hA5},
    {1'b0, 2'd2, 8'hA6},  // R7
    {1'b1, 2'd3, 8'h92},  // R2 A and B inputs
    {1'b0, 2'd0, 8'h5A},  // R6
    {1'b0, 2'd2, 8'h00}   // R3 R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic sel_n, output logic [7:0] d);
    @(negedge clk);
    cs_n = sel_n; rd_n = 1'b0; addr = a;
    #2 d = dout;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    rst = 1'b0;
    // R10 idle bus
    @(negedge clk); #1 check("R10 idle dout", dout, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][10]) bus_wr(VEC[i][9:8], VEC[i][7:0], 1'b0);
      else begin
        bus_rd(VEC[i][9:8], 1'b0, r);
        check($sformatf("R2-R8 vec%0d", i), r, VEC[i][7:0]);
      end
    end

    // R4 output enables after 0x92: A,B inputs, C both halves outputs
    check("R4 pa_oe", pa_oe, 8'h00);
    check("R4 pb_oe", pb_oe, 8'h00);
    check("R4 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h89, 1'b0);
    check("R4 pc_oe halves", pc_oe, 8'h00);
    bus_wr(2'd3, 8'h83, 1'b0);
    check("R4 pc_oe upper out", pc_oe, 8'hF0);
    check("R4 pa_oe out", pa_oe, 8'hFF);

    // R5 pins follow latch
    bus_wr(2'd3, 8'h80, 1'b0);
    bus_wr(2'd0, 8'hC7, 1'b0);
    check("R5 pa_out", pa_out, 8'hC7);
    bus_wr(2'd2, 8'h3E, 1'b0);
    check("R5 pc_out", pc_out, 8'h3E);
    // R8 middle bit set, directions kept
    bus_wr(2'd3, 8'h09, 1'b0);
    check("R8 pc_out bit4", pc_out, 8'h3E);
    bus_wr(2'd3, 8'h07, 1'b0);
    check("R8 pc_out bit3", pc_out, 8'h3E);
    bus_wr(2'd3, 8'h0D, 1'b0);
    check("R8 pc_out bit6", pc_out, 8'h7E);
    check("R8 pc_oe kept", pc_oe, 8'hFF);
    check("R8 pa_out kept", pa_out, 8'hC7);

    // R9 deselected write and read
    bus_wr(2'd0, 8'h77, 1'b1);
    check("R9 pa_out", pa_out, 8'hC7);
    bus_wr(2'd3, 8'h9B, 1'b1);
    check("R9 pa_oe", pa_oe, 8'hFF);
    bus_rd(2'd0, 1'b1, r);
    check("R9 dout", r, 8'h00);

    // R6 pins read live, no latching
    bus_wr(2'd3, 8'h92, 1'b0);
    pa_in = 8'h3D;
    bus_rd(2'd0, 1'b0, r);
    check("R6 live pins", r, 8'h3D);

    // R1 reset mid-run
    bus_wr(2'd3, 8'h80, 1'b0);
    bus_wr(2'd1, 8'hAB, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    bus_rd(2'd3, 1'b0, r);
    check("R1 ctl", r, 8'h9B);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule